// File: doc/BRIEF.md
# Two-Stage UART Baud Generator

This block turns a reference clock into the timing pulses that a UART's serial shift logic needs. The clock can first be divided by eight, or left undivided. A 16-bit clock divisor then turns it into a baud tick. An 8-bit per-bit divider counts those baud ticks and issues one bit-sample tick for every (divider + 1) of them. The resulting bit rate is the selected clock divided by divisor × (divider + 1).

The same frame-format byte that selects the prescaler also sets the data length, parity and stop bits. From these fields the block works out how many bit periods one character occupies. It also gives the four-character window that a receive-timeout counter elsewhere loads. The serial shifters and the timeout counter are not part of this block.

Configuration arrives as single-cycle write strobes with data. A divisor write of zero and a divider write below four are dropped. Every accepted write restarts all counting from zero, so a new setting takes effect with a known phase.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the divisor is 651, the divider is 15 and the mode byte is 0. A baud tick therefore appears every 651 clocks and a bit tick every 16 baud ticks. The character length reads 12 and the timeout window reads 48.
- R2: With mode bit 0 clear, baud_tick_o is high for one clock every divisor clocks. The first pulse comes divisor clocks after the clock edge that accepted the write.
- R3: With mode bit 0 set, the baud tick period is 8 × divisor clocks.
- R4: bit_tick_o pulses together with every (divider + 1)-th baud tick, counted from the last restart, and never without a baud tick.
- R5: A divisor write with data 0 is ignored: the stored divisor and the running tick schedule are unchanged.
- R6: A divider write with data below 4 is ignored: the stored divider and the running tick schedule are unchanged.
- R7: An accepted write to the divisor, the divider or the mode byte clears the prescaler and both counters, and it drops any pending tick on that edge.
- R8: Mode bits [2:1] give the data length: 3 means 6 bits, 2 means 7 bits, and 0 or 1 mean 8 bits.
- R9: Mode bits [5:3] give the parity: 0 (even) and 1 (odd) each add one parity bit, and values 2 to 7 add none.
- R10: Mode bits [7:6] equal to 3 give one stop bit, and any other value gives two. char_bits_o = 1 + data + parity + stop, which is always between 8 and 12.
- R11: tmo_bits_o equals 4 × char_bits_o.
- R12: A divisor of 1 with the prescaler off gives a baud tick on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_we_i | input | 1 | Divisor write strobe |
| div_wdata_i | input | 16 | Divisor write data |
| bdiv_we_i | input | 1 | Per-bit divider write strobe |
| bdiv_wdata_i | input | 8 | Per-bit divider write data |
| mode_we_i | input | 1 | Mode byte write strobe |
| mode_wdata_i | input | 8 | Mode byte: [0] prescale by 8, [2:1] data length, [5:3] parity, [7:6] stop bits |
| baud_tick_o | output | 1 | One-clock pulse per divisor period |
| bit_tick_o | output | 1 | One-clock bit-sample pulse |
| char_bits_o | output | 4 | Bit periods in one character |
| tmo_bits_o | output | 6 | Bit periods in the receive-timeout window |

## Verification
The period properties measure gaps only between restarts. They assume the divisor and the prescale selection stay fixed between two accepted writes, and this holds because every legal write of either one restarts the counters. The divider check counts baud ticks from the last restart or bit tick, so the stimulus never changes the divider without a restart. In the bench, each configuration is written in a single cycle and run for a fixed window. Rejected writes are placed in the middle of a window, so the schedule pushed for that window must survive them unchanged.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
  typedef struct packed {
    logic [1:0] stop_sel;
    logic [2:0] par_sel;
    logic [1:0] len_sel;
    logic       presc_on;
  } mode_t;

  localparam int unsigned MODE_W    = $bits(mode_t);
  localparam int unsigned CHAR_W    = 4;
  localparam int unsigned TMO_CHARS = 4;
  localparam int unsigned TMO_W     = 6;

  function automatic logic [CHAR_W-1:0] data_len(input logic [1:0] sel);
    case (sel)
      2'b11:   return 4'd6;
      2'b10:   return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [CHAR_W-1:0] frame_bits(input mode_t m);
    logic [CHAR_W-1:0] n;
    n = 4'd1 + data_len(m.len_sel);
    if (m.par_sel < 3'd2) n = n + 4'd1;
    n = n + ((m.stop_sel == 2'b11) ? 4'd1 : 4'd2);
    return n;
  endfunction
endpackage

// File: rtl/ubg_cfg.sv
module ubg_cfg import ubg_pkg::*; #(
  parameter int unsigned       DIV_W    = 16,
  parameter int unsigned       BDIV_W   = 8,
  parameter logic [DIV_W-1:0]  DIV_RST  = 16'h028B,
  parameter logic [BDIV_W-1:0] BDIV_RST = 8'h0F,
  parameter logic [DIV_W-1:0]  DIV_MIN  = 16'd1,
  parameter logic [BDIV_W-1:0] BDIV_MIN = 8'd4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_wdata_i,
  input  logic              bdiv_we_i,
  input  logic [BDIV_W-1:0] bdiv_wdata_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic [DIV_W-1:0]  divisor_o,
  output logic [BDIV_W-1:0] divider_o,
  output mode_t             mode_o,
  output logic              reload_o
);
  logic div_ok, bdiv_ok;
  assign div_ok   = div_we_i  && (div_wdata_i  >= DIV_MIN);
  assign bdiv_ok  = bdiv_we_i && (bdiv_wdata_i >= BDIV_MIN);
  assign reload_o = div_ok | bdiv_ok | mode_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      divisor_o <= DIV_RST;
      divider_o <= BDIV_RST;
      mode_o    <= '0;
    end else begin
      if (div_ok)    divisor_o <= div_wdata_i;
      if (bdiv_ok)   divider_o <= bdiv_wdata_i;
      if (mode_we_i) mode_o    <= mode_t'(mode_wdata_i);
    end
  end
endmodule

// File: rtl/ubg_prescale.sv
module ubg_prescale #(
  parameter int unsigned LOG2 = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sel_i,
  output logic en_o
);
  logic [LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // bypassed: enable every clock; otherwise once per 2**LOG2 clocks
  assign en_o = !sel_i || (&cnt_q);
endmodule

// File: rtl/ubg_modcnt.sv
module ubg_modcnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] last_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ubg_frame.sv
module ubg_frame import ubg_pkg::*; (
  input  mode_t             mode_i,
  output logic [CHAR_W-1:0] char_bits_o,
  output logic [TMO_W-1:0]  tmo_bits_o
);
  assign char_bits_o = frame_bits(mode_i);
  assign tmo_bits_o  = TMO_W'(32'(char_bits_o) * TMO_CHARS);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen import ubg_pkg::*; #(
  parameter int unsigned       DIV_W    = 16,
  parameter int unsigned       BDIV_W   = 8,
  parameter int unsigned       PRE_LOG2 = 3,
  parameter logic [DIV_W-1:0]  DIV_RST  = 16'h028B,
  parameter logic [BDIV_W-1:0] BDIV_RST = 8'h0F,
  parameter logic [DIV_W-1:0]  DIV_MIN  = 16'd1,
  parameter logic [BDIV_W-1:0] BDIV_MIN = 8'd4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_wdata_i,
  input  logic              bdiv_we_i,
  input  logic [BDIV_W-1:0] bdiv_wdata_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output logic              baud_tick_o,
  output logic              bit_tick_o,
  output logic [CHAR_W-1:0] char_bits_o,
  output logic [TMO_W-1:0]  tmo_bits_o
);
  localparam logic [DIV_W-1:0] ONE_D = 1;

  logic [DIV_W-1:0]  divisor_q;
  logic [BDIV_W-1:0] divider_q;
  mode_t             mode_q;
  logic              reload;
  logic              pre_en, baud_wrap, bit_wrap;

  ubg_cfg #(
    .DIV_W(DIV_W), .BDIV_W(BDIV_W), .DIV_RST(DIV_RST), .BDIV_RST(BDIV_RST),
    .DIV_MIN(DIV_MIN), .BDIV_MIN(BDIV_MIN)
  ) u_cfg (
    .clk_i, .rst_ni,
    .div_we_i, .div_wdata_i, .bdiv_we_i, .bdiv_wdata_i, .mode_we_i, .mode_wdata_i,
    .divisor_o(divisor_q), .divider_o(divider_q), .mode_o(mode_q), .reload_o(reload)
  );

  ubg_prescale #(.LOG2(PRE_LOG2)) u_pre (
    .clk_i, .rst_ni, .clr_i(reload), .sel_i(mode_q.presc_on), .en_o(pre_en)
  );

  ubg_modcnt #(.W(DIV_W)) u_div_cnt (
    .clk_i, .rst_ni, .clr_i(reload), .en_i(pre_en),
    .last_i(divisor_q - ONE_D), .wrap_o(baud_wrap)
  );

  ubg_modcnt #(.W(BDIV_W)) u_bit_cnt (
    .clk_i, .rst_ni, .clr_i(reload), .en_i(baud_wrap),
    .last_i(divider_q), .wrap_o(bit_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_tick_o <= 1'b0;
      bit_tick_o  <= 1'b0;
    end else if (reload) begin
      baud_tick_o <= 1'b0;
      bit_tick_o  <= 1'b0;
    end else begin
      baud_tick_o <= baud_wrap;
      bit_tick_o  <= bit_wrap;
    end
  end

  ubg_frame u_frame (.mode_i(mode_q), .char_bits_o, .tmo_bits_o);
endmodule

// File: rtl/ubg_checker.sv
module ubg_checker import ubg_pkg::*; #(
  parameter int unsigned       DIV_W    = 16,
  parameter int unsigned       BDIV_W   = 8,
  parameter int unsigned       PRE_LOG2 = 3,
  parameter logic [BDIV_W-1:0] BDIV_MIN = 8'd4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              div_we_i,
  input logic [DIV_W-1:0]  div_wdata_i,
  input logic              bdiv_we_i,
  input logic [BDIV_W-1:0] bdiv_wdata_i,
  input logic              baud_tick_o,
  input logic              bit_tick_o,
  input logic [CHAR_W-1:0] char_bits_o,
  input logic [DIV_W-1:0]  divisor_q,
  input logic [BDIV_W-1:0] divider_q,
  input logic              presc_on,
  input logic              reload
);
  localparam int unsigned PER_W = DIV_W + PRE_LOG2 + 1;

  logic [PER_W-1:0]  gap_q, period;
  logic [BDIV_W:0]   btk_q;

  assign period = presc_on ? (PER_W'(divisor_q) << PRE_LOG2) : PER_W'(divisor_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '0;
    else if (reload)      gap_q <= '0;
    else if (baud_tick_o) gap_q <= PER_W'(1);
    else                  gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          btk_q <= '0;
    else if (reload)      btk_q <= '0;
    else if (bit_tick_o)  btk_q <= '0;
    else if (baud_tick_o) btk_q <= btk_q + 1'b1;
  end

  // R2, R3 and R12 share this period check
  assert_baud_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |-> gap_q == period);

  assert_bit_on_baud_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> baud_tick_o);

  assert_bit_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> btk_q == (BDIV_W+1)'(divider_q));

  assert_div_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_we_i && div_wdata_i == '0) |=> $stable(divisor_q));

  assert_bdiv_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bdiv_we_i && bdiv_wdata_i < BDIV_MIN) |=> $stable(divider_q));

  assert_reload_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (!baud_tick_o && !bit_tick_o));

  assert_char_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_bits_o >= 4'd8) && (char_bits_o <= 4'd12));
endmodule

bind uart_baud_gen ubg_checker #(
  .DIV_W(DIV_W), .BDIV_W(BDIV_W), .PRE_LOG2(PRE_LOG2), .BDIV_MIN(BDIV_MIN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .div_we_i(div_we_i), .div_wdata_i(div_wdata_i),
  .bdiv_we_i(bdiv_we_i), .bdiv_wdata_i(bdiv_wdata_i),
  .baud_tick_o(baud_tick_o), .bit_tick_o(bit_tick_o), .char_bits_o(char_bits_o),
  .divisor_q(divisor_q), .divider_q(divider_q),
  .presc_on(mode_q.presc_on), .reload(reload)
);

// File: tb/uart_baud_gen_test.sv
module uart_baud_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        div_we_i = 1'b0, bdiv_we_i = 1'b0, mode_we_i = 1'b0;
  logic [15:0] div_wdata_i = '0;
  logic [7:0]  bdiv_wdata_i = '0;
  logic [7:0]  mode_wdata_i = '0;
  logic        baud_tick_o, bit_tick_o;
  logic [3:0]  char_bits_o;
  logic [5:0]  tmo_bits_o;

  uart_baud_gen uut (
    .clk_i, .rst_ni, .div_we_i, .div_wdata_i, .bdiv_we_i, .bdiv_wdata_i,
    .mode_we_i, .mode_wdata_i, .baud_tick_o, .bit_tick_o, .char_bits_o, .tmo_bits_o
  );

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int    n_chk = 0, n_bad = 0;
  int    q_baud[$];
  int    q_bit[$];
  int    e_b, e_t;
  string tag = "R1";
  logic  mon_en = 1'b0;

  // monitor: pops expected tick cycles as the design produces ticks
  always @(negedge clk_i) begin
    if (mon_en && baud_tick_o) begin
      n_chk++;
      if (q_baud.size() == 0) begin
        n_bad++;
        $display("FAIL %s baud tick: actual cycle %0d expected none", tag, cyc);
      end else begin
        e_b = q_baud.pop_front();
        if (e_b != cyc) begin
          n_bad++;
          $display("FAIL %s baud tick: actual cycle %0d expected %0d", tag, cyc, e_b);
        end
      end
    end
    if (mon_en && bit_tick_o) begin
      n_chk++;
      if (q_bit.size() == 0) begin
        n_bad++;
        $display("FAIL R4/%s bit tick: actual cycle %0d expected none", tag, cyc);
      end else begin
        e_t = q_bit.pop_front();
        if (e_t != cyc) begin
          n_bad++;
          $display("FAIL R4/%s bit tick: actual cycle %0d expected %0d", tag, cyc, e_t);
        end
      end
    end
  end

  function automatic int exp_char(input logic [7:0] m);
    int d, p, s;
    d = (m[2:1] == 2'd3) ? 6 : (m[2:1] == 2'd2) ? 7 : 8;
    p = (m[5:3] <= 3'd1) ? 1 : 0;
    s = (m[7:6] == 2'd3) ? 1 : 2;
    return 1 + d + p + s;
  endfunction

  task automatic check_eq(input string t, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic end_window();
    n_chk++;
    if (q_baud.size() != 0 || q_bit.size() != 0) begin
      n_bad++;
      $display("FAIL %s missing ticks: actual %0d/%0d pending expected 0/0",
               tag, q_baud.size(), q_bit.size());
    end
    q_baud.delete();
    q_bit.delete();
  endtask

  // driver: expected schedule for a window that starts at edge w
  task automatic push_sched(input int w, input int p, input int bd, input int dur);
    for (int k = 1; k * p <= dur - 1; k++) q_baud.push_back(w + k * p);
    for (int k = 1; k * p * (bd + 1) <= dur - 1; k++) q_bit.push_back(w + k * p * (bd + 1));
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  // ill: 0 none, 1 zero divisor write mid-window, 2 divider write of 3 mid-window
  task automatic run_cfg(input string t, input string ft, input int dv, input int bd,
                         input logic [7:0] md, input int dur, input int ill);
    int w, p;
    end_window();
    w = cyc + 1;
    p = dv * (md[0] ? 8 : 1);
    push_sched(w, p, bd, dur);
    tag = t;
    div_we_i = 1'b1;  div_wdata_i  = 16'(dv);
    bdiv_we_i = 1'b1; bdiv_wdata_i = 8'(bd);
    mode_we_i = 1'b1; mode_wdata_i = md;
    step(1);
    div_we_i = 1'b0; bdiv_we_i = 1'b0; mode_we_i = 1'b0;
    check_eq({ft, " char bits"}, int'(char_bits_o), exp_char(md));
    check_eq("R11 timeout window", int'(tmo_bits_o), 4 * exp_char(md));
    if (ill != 0) begin
      step(dur / 2 - 1);
      if (ill == 1) begin div_we_i = 1'b1;  div_wdata_i  = 16'd0; end
      else          begin bdiv_we_i = 1'b1; bdiv_wdata_i = 8'd3;  end
      step(1);
      div_we_i = 1'b0; bdiv_we_i = 1'b0;
      step(dur - 1 - dur / 2);
    end else begin
      step(dur - 1);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    step(3);
    // R1: reset schedule, divisor 651, 16 baud ticks per bit
    push_sched(cyc, 651, 15, 10500);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    tag = "R1";
    check_eq("R1 reset char bits", int'(char_bits_o), 12);
    check_eq("R1 reset timeout window", int'(tmo_bits_o), 48);
    step(10499);
    run_cfg("R2",  "R10", 3, 4, 8'h00, 100, 0);
    run_cfg("R12", "R10", 1, 4, 8'hE0, 40,  0);  // stop 1, no parity, 8 data -> 10
    run_cfg("R3",  "R8",  2, 5, 8'h07, 300, 0);  // prescale, 6 data, even, 2 stop -> 10
    run_cfg("R5",  "R9",  5, 4, 8'hCC, 120, 1);  // 7 data, odd, 1 stop -> 10
    run_cfg("R6",  "R8",  4, 6, 8'hFE, 150, 2);  // 6 data, no parity, 1 stop -> 8
    run_cfg("R7",  "R9",  4, 6, 8'hFE, 150, 0);  // same setting rewritten: restart phase
    run_cfg("R2",  "R9",  7, 4, 8'h08, 90,  0);  // 8 data, odd, 2 stop -> 12
    end_window();
    summary();
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule